// File: doc/BRIEF.md
# Bus Cycle Status Command Decoder

This block sits beside a processor that announces each bus cycle with a three-bit cycle-type code. It turns that code into the strobes that the memory and I/O side of the system needs:
- an address latch pulse;
- a data transceiver enable and a transceiver direction;
- separate read and write commands for memory and for I/O;
- early write strobes for memory and for I/O;
- an interrupt acknowledge strobe.

The code rests at the passive value 111 between cycles. A cycle begins on the first rising clock edge at which the sampled code is anything else. The code sampled at that edge is held for the whole cycle, so later changes to the status lines do not alter which commands fire. The cycle ends, and every output goes back to its inactive level, on the edge that samples 111 again.

Clock numbering: clock 1 is the clock after the starting edge, clock 2 the one after that, and so on.

| Clock | Outputs |
|---|---|
| 1 | address latch pulse; direction set; advanced write strobe for write cycles |
| 2 and 3 | normal command strobe; advanced write stays active in clock 2 |
| 4 onward | nothing further until the code returns to passive |

Top module: `bus_cmd_decoder`

## Requirements
- R1: While reset is asserted, and on the first clock after it, outputs are at rest: `ale`=0, `xcvr_en`=0, `xcvr_dir`=1, and all seven active-low strobes are 1.
- R2: `ale` is 1 in clock 1 of every cycle and 0 in every other clock, for every non-passive code, halt (011) included.
- R3: The code sampled at the starting edge decides the commands for the whole cycle. A different non-passive code presented in later clocks of the same cycle has no effect on any output.
- R4: Codes 100 (opcode fetch) and 101 (memory read) drive `mem_rd_n` low, and code 001 (I/O read) drives `io_rd_n` low, in clocks 2 and 3 only.
- R5: Code 110 (memory write) drives `mem_wr_n` low, and code 010 (I/O write) drives `io_wr_n` low, in clocks 2 and 3 only.
- R6: For code 110, `mem_wr_early_n` is low in clocks 1 and 2. For code 010, `io_wr_early_n` is low in clocks 1 and 2. Each early strobe therefore falls one clock before its normal write strobe.
- R7: Code 000 (interrupt acknowledge) drives `int_ack_n` low in clocks 2 and 3 only.
- R8: Code 011 (halt) produces the address latch pulse but no command strobe and no transceiver enable.
- R9: `xcvr_en` is 1 exactly while one of the five normal command strobes is low.
  - `xcvr_dir` is 1 (data outward) for write cycles and 0 (data inward) for read and acknowledge cycles.
  - `xcvr_dir` takes its value in clock 1 and holds it until the cycle ends, so it is settled before the enable rises.
- R10: On the clock after the edge that samples code 111, all outputs are at their rest values (as in R1), whatever clock the cycle had reached.
- R11: From clock 4 until passive is sampled, no strobe or enable is active. A new cycle starts only after passive has been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_stat | input | 3 | Cycle-type code from the processor, 111 = passive |
| ale | output | 1 | Address latch pulse, active high |
| xcvr_en | output | 1 | Data transceiver enable, active high |
| xcvr_dir | output | 1 | Transceiver direction, 1 = processor drives the bus |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| mem_wr_early_n | output | 1 | Early memory write strobe, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| io_wr_early_n | output | 1 | Early I/O write strobe, active low |
| int_ack_n | output | 1 | Interrupt acknowledge strobe, active low |

## Verification
The bench presents all seven non-passive codes. Each code is tried with cycle lengths of one to five clocks before passive returns. This shows that every strobe starts in the right clock, stops at clock 3, and is cut off early when a cycle ends early.

A second sweep changes the code to another non-passive value after the first clock. It separates a design that latches the cycle type from one that decodes the live status lines.

The transceiver enable and direction are compared on their own in every clock, so that an ordering error between them is reported apart from strobe errors. Expected values come from a per-clock table keyed by code and clock number.

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_stat,
  output logic       ale,
  output logic       xcvr_en,
  output logic       xcvr_dir,
  output logic       mem_rd_n,
  output logic       mem_wr_n,
  output logic       mem_wr_early_n,
  output logic       io_rd_n,
  output logic       io_wr_n,
  output logic       io_wr_early_n,
  output logic       int_ack_n
);

  localparam logic [2:0] ST_INTA  = 3'b000;
  localparam logic [2:0] ST_IORD  = 3'b001;
  localparam logic [2:0] ST_IOWR  = 3'b010;
  localparam logic [2:0] ST_HALT  = 3'b011;
  localparam logic [2:0] ST_FETCH = 3'b100;
  localparam logic [2:0] ST_MRD   = 3'b101;
  localparam logic [2:0] ST_MWR   = 3'b110;
  localparam logic [2:0] ST_IDLE  = 3'b111;

  localparam logic [2:0] PH_REST = 3'd0;
  localparam logic [2:0] PH_ONE  = 3'd1;
  localparam logic [2:0] PH_TWO  = 3'd2;
  localparam logic [2:0] PH_THR  = 3'd3;
  localparam logic [2:0] PH_HOLD = 3'd4;

  logic [2:0] phase;
  logic [2:0] kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_REST;
      kind  <= ST_IDLE;
    end else if (bus_stat == ST_IDLE) begin
      phase <= PH_REST;
      kind  <= ST_IDLE;
    end else if (phase == PH_REST) begin
      phase <= PH_ONE;
      kind  <= bus_stat;
    end else if (phase != PH_HOLD) begin
      phase <= phase + 3'd1;
    end
  end

  logic in_cyc, cmd_win, adv_win;
  logic is_mrd, is_mwr, is_iord, is_iowr, is_inta;

  assign in_cyc  = (phase != PH_REST);
  assign cmd_win = (phase == PH_TWO) || (phase == PH_THR);
  assign adv_win = (phase == PH_ONE) || (phase == PH_TWO);

  assign is_mrd  = (kind == ST_FETCH) || (kind == ST_MRD);
  assign is_mwr  = (kind == ST_MWR);
  assign is_iord = (kind == ST_IORD);
  assign is_iowr = (kind == ST_IOWR);
  assign is_inta = (kind == ST_INTA);

  assign ale            = (phase == PH_ONE);
  assign mem_rd_n       = ~(cmd_win & is_mrd);
  assign mem_wr_n       = ~(cmd_win & is_mwr);
  assign io_rd_n        = ~(cmd_win & is_iord);
  assign io_wr_n        = ~(cmd_win & is_iowr);
  assign int_ack_n      = ~(cmd_win & is_inta);
  assign mem_wr_early_n = ~(adv_win & is_mwr);
  assign io_wr_early_n  = ~(adv_win & is_iowr);
  assign xcvr_en        = cmd_win & (kind != ST_HALT);
  assign xcvr_dir       = ~(in_cyc & (is_mrd | is_iord | is_inta));

  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  p_en_tracks_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xcvr_en == (!mem_rd_n || !mem_wr_n || !io_rd_n || !io_wr_n || !int_ack_n));

  p_dir_settled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xcvr_en) |-> $stable(xcvr_dir));

  p_one_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~mem_rd_n, ~mem_wr_n, ~io_rd_n, ~io_wr_n, ~int_ack_n}) <= 1);

  p_mem_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr_n) |-> $past(!mem_wr_early_n));

  p_io_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_wr_n) |-> $past(!io_wr_early_n));

  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ST_HALT) |-> (!xcvr_en && mem_rd_n && io_rd_n && int_ack_n));

  p_passive_rest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stat == ST_IDLE) |=> (!ale && !xcvr_en && xcvr_dir && mem_rd_n && mem_wr_n
                              && io_rd_n && io_wr_n && int_ack_n
                              && mem_wr_early_n && io_wr_early_n));

endmodule

// File: tb/bus_cmd_decoder_bench.sv
module bus_cmd_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_stat = 3'b111;
  logic ale, xcvr_en, xcvr_dir, mem_rd_n, mem_wr_n, mem_wr_early_n;
  logic io_rd_n, io_wr_n, io_wr_early_n, int_ack_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_cmd_decoder u_bus_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .bus_stat(bus_stat),
    .ale(ale), .xcvr_en(xcvr_en), .xcvr_dir(xcvr_dir),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_wr_early_n(mem_wr_early_n),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_wr_early_n(io_wr_early_n),
    .int_ack_n(int_ack_n)
  );

  // packed: ale, en, dir, mrd, mwr, mwr_early, iord, iowr, iowr_early, inta
  function automatic logic [9:0] expect_vec(input logic [2:0] code, input int ph);
    logic a, e, d, cmd, adv;
    if (ph == 0) return 10'b0011111111;
    a   = (ph == 1);
    cmd = (ph == 2) || (ph == 3);
    adv = (ph == 1) || (ph == 2);
    e   = cmd && (code != 3'b011);
    d   = !((code == 3'b100) || (code == 3'b101) || (code == 3'b001) || (code == 3'b000));
    return {a, e, d,
            !(cmd && (code == 3'b100 || code == 3'b101)),
            !(cmd && code == 3'b110),
            !(adv && code == 3'b110),
            !(cmd && code == 3'b001),
            !(cmd && code == 3'b010),
            !(adv && code == 3'b010),
            !(cmd && code == 3'b000)};
  endfunction

  function automatic logic [9:0] actual_vec();
    return {ale, xcvr_en, xcvr_dir, mem_rd_n, mem_wr_n, mem_wr_early_n,
            io_rd_n, io_wr_n, io_wr_early_n, int_ack_n};
  endfunction

  function automatic string code_tag(input logic [2:0] code);
    case (code)
      3'b000: return "R7";
      3'b011: return "R8";
      3'b010, 3'b110: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input logic [9:0] act, input logic [9:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic run_cycle(input logic [2:0] code, input int len, input logic [2:0] alt);
    for (int i = 1; i <= len; i++) begin
      logic [9:0] ev;
      string tg;
      bus_stat = (i == 1) ? code : alt;
      @(posedge clk);
      @(negedge clk);
      ev = expect_vec(code, (i > 4) ? 4 : i);
      if (i == 1) tg = "R2";
      else if (alt != code) tg = "R3";
      else if (i >= 4) tg = "R11";
      else tg = code_tag(code);
      check(actual_vec(), ev, tg);
      check({8'd0, xcvr_en, xcvr_dir}, {8'd0, ev[8], ev[7]}, "R9");
      if (code == 3'b110 || code == 3'b010)
        check({9'd0, mem_wr_early_n & io_wr_early_n}, {9'd0, ev[4] & ev[1]}, "R6");
    end
    bus_stat = 3'b111;
    @(posedge clk);
    @(negedge clk);
    check(actual_vec(), expect_vec(code, 0), "R10");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #3;
    check(actual_vec(), expect_vec(3'b111, 0), "R1");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(actual_vec(), expect_vec(3'b111, 0), "R1");
    for (int c = 0; c < 7; c++)
      for (int l = 1; l <= 5; l++)
        run_cycle(3'(c), l, 3'(c));
    for (int c = 0; c < 7; c++)
      run_cycle(3'(c), 4, 3'((c + 1) % 7));
    for (int c = 0; c < 7; c++)
      run_cycle(3'(c), 3, 3'((c + 3) % 7));
    run_cycle(3'b110, 5, 3'b101);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule